// File: doc/BRIEF.md
# Five-State Recovering Sequence Counter

This block is a three-bit synchronous state machine. While its enable is high it steps through a fixed, non-binary loop of five codes. Its next-state logic is written as JK excitation equations, one JK cell for each state bit. Because the three codes outside the loop are not don't-cares in those equations, each of them goes to a known successor and returns to the loop in at most two enabled clocks.

A flag output is high while the present code lies outside the loop, so a neighbouring block can see a corrupted state. A synchronous reset loads a parameter-selected start code, which is 2 by default. When the enable is low, the state holds.

Top module: `seqc_counter`

## Requirements
- R1: With `en` high and `rst` low, each rising clock edge advances `state` along the loop 2→6→1→7→5→2. Bit 2 of `state` is the most significant bit.
- R2: A rising edge with `rst` high loads `state` with the parameter `RST_CODE` (default 2), even when `en` is high.
- R3: A rising edge with `rst` low and `en` low leaves `state` unchanged.
- R4: `off_loop` is high exactly when `state` is 0, 3 or 4. It depends only on the present `state`.
- R5: From code 0, one enabled edge gives code 6.
- R6: From code 3, one enabled edge gives code 7.
- R7: From code 4, one enabled edge gives code 3 and a second enabled edge gives code 7, so the loop is reached within two enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads `RST_CODE` |
| en | input | 1 | Count enable, active high |
| state | output | 3 | Present state code, bit 2 most significant |
| off_loop | output | 1 | High while `state` is outside the five-code loop |

## Verification
The bench builds eight copies of the counter, one for each reset code, so that every code, unused ones included, is a start state. For each copy it checks the successor against a table taken from the requirements. An error in a K term would send an unused code to the wrong place, and in the worst case the state would be trapped outside the loop. The bench follows all eight copies for several laps to confirm that the loop repeats. It also checks that a low enable freezes every copy, and that reset overrides a high enable. A design that gave enable priority would keep counting through reset.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
    localparam int unsigned STATE_W   = 3;
    localparam int unsigned NUM_CODES = 1 << STATE_W;

    typedef logic [STATE_W-1:0] code_t;

    // Registered values of the counter, next-value form built in one process.
    typedef struct packed {
        code_t code;
    } seqc_regs_t;

    // Codes that belong to the loop: 1, 2, 5, 6, 7.
    localparam logic [NUM_CODES-1:0] LOOP_MASK = 8'b1110_0110;
endpackage

// File: rtl/seqc_jk_bit.sv
// Next value of one flip-flop under JK rules: set on J, clear on K, toggle on both.
module seqc_jk_bit (
    input  logic q,
    input  logic j,
    input  logic k,
    output logic q_next
);
    always_comb begin
        q_next = (j & ~q) | (~k & q);
    end
endmodule

// File: rtl/seqc_excite.sv
// J and K inputs for the three state bits (bit 2 = A, bit 1 = B, bit 0 = C).
module seqc_excite
    import seqc_pkg::*;
(
    input  code_t cur,
    output code_t j_vec,
    output code_t k_vec
);
    logic bit_a, bit_b, bit_c;

    always_comb begin
        bit_a = cur[2];
        bit_b = cur[1];
        bit_c = cur[0];
        j_vec[2] = 1'b1;
        k_vec[2] = ~bit_b | ~bit_c;
        j_vec[1] = 1'b1;
        k_vec[1] = bit_a;
        j_vec[0] = bit_a;
        k_vec[0] = bit_a & ~bit_b;
    end
endmodule

// File: rtl/seqc_counter.sv
module seqc_counter
    import seqc_pkg::*;
#(
    parameter logic [2:0] RST_CODE = 3'd2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [2:0] state,
    output logic       off_loop
);
    seqc_regs_t regs_d, regs_q;
    code_t      j_vec, k_vec, step_code;

    seqc_excite excite_i (
        .cur   (regs_q.code),
        .j_vec (j_vec),
        .k_vec (k_vec)
    );

    for (genvar b = 0; b < STATE_W; b++) begin : g_bit
        seqc_jk_bit jk_i (
            .q      (regs_q.code[b]),
            .j      (j_vec[b]),
            .k      (k_vec[b]),
            .q_next (step_code[b])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.code = RST_CODE;
        end else if (en) begin
            regs_d.code = step_code;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state    = regs_q.code;
    assign off_loop = ~LOOP_MASK[regs_q.code];
endmodule

// File: rtl/seqc_counter_chk.sv
module seqc_counter_chk #(
    parameter logic [2:0] RST_CODE = 3'd2
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [2:0] state,
    input logic       off_loop
);
    AST_RESET_LOAD: assert property (@(posedge clk) rst |=> state == RST_CODE) // R2
        else $error("reset code not loaded");
    AST_HOLD: assert property (@(posedge clk) disable iff (rst) (!en && !$past(rst)) |=> $stable(state)) // R3
        else $error("state moved with enable low");
    AST_LOOP_CLOSED: assert property (@(posedge clk) disable iff (rst) (en && !off_loop) |=> !off_loop) // R1
        else $error("left the loop");
    AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (rst) (en && state == 3'd0) |=> state == 3'd6) // R5
        else $error("code 0 successor wrong");
    AST_THREE_EXIT: assert property (@(posedge clk) disable iff (rst) (en && state == 3'd3) |=> state == 3'd7) // R6
        else $error("code 3 successor wrong");
    AST_FOUR_EXIT: assert property (@(posedge clk) disable iff (rst) (en && state == 3'd4) |=> state == 3'd3) // R7
        else $error("code 4 successor wrong");
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst) (en && state == 3'd4) |=> off_loop) // R4
        else $error("flag low on code 3");
endmodule

bind seqc_counter seqc_counter_chk #(.RST_CODE(RST_CODE)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .state    (state),
    .off_loop (off_loop)
);

// File: tb/seqc_counter_tb_top.sv
`timescale 1ns/1ps
module seqc_counter_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [2:0] st_w [8];
    logic       fl_w [8];
    int checks = 0;
    int errors = 0;
    logic [2:0] model [8];

    always #2.5 clk = ~clk;

    for (genvar k = 0; k < 8; k++) begin : g_dut
        if (k == 2) begin : g_main
            seqc_counter dut_i (.clk(clk), .rst(rst), .en(en), .state(st_w[k]), .off_loop(fl_w[k]));
        end else begin : g_alt
            seqc_counter #(.RST_CODE(3'(k))) dut_i (.clk(clk), .rst(rst), .en(en), .state(st_w[k]), .off_loop(fl_w[k]));
        end
    end

    // Successor table from the requirements (R1, R5, R6, R7).
    function automatic logic [2:0] succ(input logic [2:0] c);
        case (c)
            3'd0: succ = 3'd6;
            3'd1: succ = 3'd7;
            3'd2: succ = 3'd6;
            3'd3: succ = 3'd7;
            3'd4: succ = 3'd3;
            3'd5: succ = 3'd2;
            3'd6: succ = 3'd1;
            default: succ = 3'd5;
        endcase
    endfunction

    function automatic logic off_of(input logic [2:0] c);
        off_of = (c == 3'd0) || (c == 3'd3) || (c == 3'd4);
    endfunction

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int k = 0; k < 8; k++) begin
            chk(st_w[k], model[k], tag);
            chk(fl_w[k], off_of(model[k]), "R4 flag");
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) model[k] = 3'(k);
        check_all("R2 reset load");
        rst = 1'b0;
        en  = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R3 hold");
        en = 1'b1;
        // First step from every code, then a second step so 4 reaches 7 (R7).
        for (int s = 0; s < 12; s++) begin
            @(negedge clk);
            for (int k = 0; k < 8; k++) model[k] = succ(model[k]);
            if (s == 0) check_all("R5 R6 R7 R1 first step");
            else if (s == 1) begin
                chk(st_w[4], 3'd7, "R7 rejoin in two");
                check_all("R1 second step");
            end else check_all("R1 loop");
        end
        // Hold in mid-loop.
        en = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R3 hold mid-loop");
        // Reset with enable high.
        en  = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 8; k++) model[k] = 3'(k);
        check_all("R2 reset over enable");
        rst = 1'b0;
        // Full lap of the main copy returns to 2 after five steps.
        repeat (5) @(negedge clk);
        chk(st_w[2], 3'd2, "R1 lap returns to 2");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule